// File: doc/BRIEF.md
# Clock Source Switch Controller with Shared Watchdog Counter

This block picks the system clock source of a small processor core and runs the watchdog. Software writes a one-byte control register. The register holds a 2-bit source select, a 3-bit internal RC frequency code, and two read-only status bits. Writing a new select code starts a switch to the primary oscillator, the low-power secondary oscillator or the internal RC oscillator. The analog oscillators are outside the block. Each one is represented by a single-cycle tick input.

A single counter does two jobs. When the core is running normally, it is the watchdog and counts internal-oscillator ticks. During a switch to a crystal-type primary oscillator, it becomes the start-up timer and counts ticks of the new oscillator. While any switch is in progress, the watchdog is suspended: it does not count, clear requests are ignored, and no timeout is raised. When the switch completes, the counter restarts from zero, so the watchdog period begins in step with the new clock.

At reset the core runs from the internal RC oscillator. A start-up switch to the primary oscillator begins at once.

Top module: `clksw_ctrl`

## Requirements
- R1: During and after reset, rd_data reads 0x00, sw_done and wdt_timeout are low, and src_sel reads 10 (internal RC). A switch to the primary source begins on the first clock after reset is released.
- R2: Source codes are 00 primary, 01 secondary and 10 internal RC. Writing one of these codes while idle, when it differs from the running source, starts a switch. A switch that needs no start-up wait completes on the next clock edge. At that edge src_sel takes the new code and sw_done is high for exactly one cycle.
- R3: cfg_mode values 000, 001 and 010 are crystal-type. A switch to the primary source in one of these modes completes on the edge that samples the OST_TICKS-th (default 1024) tick_pri pulse seen during the switch. Until then src_sel keeps the old code.
- R4: Writing select code 11 starts no switch, and src_sel does not change. The select field reads back 11.
- R5: A select write made during a switch is held. It starts its own switch on the clock edge that follows the first sw_done pulse. The second sw_done therefore comes two cycles after the first.
- R6: While a switch is in progress the watchdog does not count and ignores wdt_clr, and wdt_timeout stays low.
- R7: A completed switch restarts the counter from zero. With wdt_en high and tick_int high every cycle, wdt_timeout fires WDT_TICKS (default 2048) clocks after the last sw_done.
- R8: When idle with wdt_en high, each tick_int advances the watchdog. The WDT_TICKS-th tick gives a one-cycle wdt_timeout pulse and the count restarts. A wdt_clr restarts the count from zero.
- R9: The register reads as follows: bit 7 is 0; bits 6:4 are the frequency code last written; bit 3 is primary status; bit 2 is stable status; bits 1:0 are the select code last written.
- R10: Bit 3 is 1 one cycle after the core is running from the primary source with no switch pending. It is 0 while a switch is in progress and while running from any other source.
- R11: Bit 2 follows int_stable, delayed by SYNC_STAGES (default 2) clock edges.
- R12: Writing the select code of the source already running starts no switch, and sw_done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control register write strobe |
| wr_freq | input | 3 | Internal RC frequency code to write |
| wr_sel | input | 2 | Source select code to write |
| cfg_mode | input | 3 | Configured primary oscillator mode |
| wdt_en | input | 1 | Watchdog enable |
| wdt_clr | input | 1 | Watchdog clear request |
| tick_pri | input | 1 | Primary oscillator tick |
| tick_int | input | 1 | Internal RC oscillator tick (watchdog time base) |
| int_stable | input | 1 | Internal oscillator frequency stable |
| rd_data | output | 8 | Control register read value |
| src_sel | output | 2 | Code of the source currently running |
| sw_done | output | 1 | One-cycle pulse when a switch completes |
| wdt_timeout | output | 1 | One-cycle watchdog timeout pulse |

## Verification
Two faults in the shared counter show up only late. If the counter is not restarted when a switch completes, the timeout moves away from exactly WDT_TICKS clocks after sw_done. If the counter is not suspended during a long crystal switch, wdt_timeout fires inside the switch. Either error appears at the ports thousands of cycles later, so the bench counts every cycle of both windows.

Three faults in the switch sequencer show up at once. A wrong busy or target state makes sw_done arrive one edge early or late, or puts the wrong code on src_sel. A lost pending write removes the second sw_done two cycles after the first.

A wrong status register changes rd_data one cycle after the change that caused it.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

   typedef enum logic [1:0] {
      SRC_PRI = 2'b00,
      SRC_SEC = 2'b01,
      SRC_INT = 2'b10
   } src_e;

   localparam logic [1:0] SEL_RSVD = 2'b11;

   // Crystal-type primary modes need the start-up wait.
   function automatic logic is_crystal(input logic [2:0] mode);
      return (mode == 3'b000) || (mode == 3'b001) || (mode == 3'b010);
   endfunction

endpackage

// File: rtl/clksw_seq.sv
module clksw_seq
   import clksw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en_i,
   input  logic [1:0] wr_sel_i,
   input  logic [2:0] cfg_mode_i,
   input  logic       ost_done_i,
   output logic       busy_o,
   output logic       start_o,
   output logic       finish_o,
   output logic       need_ost_o,
   output logic       done_o,
   output src_e       act_src_o
);

   logic       busy_q, pend_q, done_q;
   logic [1:0] pend_sel_q;
   src_e       tgt_q, act_q;
   logic       cand_vld;
   logic [1:0] cand_sel;

   always_comb begin
      if (wr_en_i) begin
         cand_vld = 1'b1;
         cand_sel = wr_sel_i;
      end else begin
         cand_vld = pend_q;
         cand_sel = pend_sel_q;
      end
   end

   assign need_ost_o = (tgt_q == SRC_PRI) && is_crystal(cfg_mode_i);
   assign finish_o   = busy_q && (!need_ost_o || ost_done_i);
   assign start_o    = !busy_q && cand_vld && (cand_sel != SEL_RSVD) &&
                       (cand_sel != act_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b1;
         tgt_q      <= SRC_PRI;
         act_q      <= SRC_INT;
         pend_q     <= 1'b0;
         pend_sel_q <= 2'b00;
         done_q     <= 1'b0;
      end else begin
         done_q <= finish_o;
         if (finish_o) begin
            busy_q <= 1'b0;
            act_q  <= tgt_q;
         end else if (start_o) begin
            busy_q <= 1'b1;
            tgt_q  <= src_e'(cand_sel);
         end
         if (busy_q && wr_en_i) begin
            pend_q     <= 1'b1;
            pend_sel_q <= wr_sel_i;
         end else if (!busy_q) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign busy_o    = busy_q;
   assign done_o    = done_q;
   assign act_src_o = act_q;

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R4
   rsvd_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && wr_en_i && wr_sel_i == SEL_RSVD) |=> !busy_q);

   // R3
   src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> $stable(act_q));

endmodule

// File: rtl/clksw_shared_cnt.sv
module clksw_shared_cnt #(
   parameter int OST_TICKS = 1024,
   parameter int WDT_TICKS = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_i,
   input  logic restart_i,
   input  logic need_ost_i,
   input  logic tick_ost_i,
   input  logic tick_wdt_i,
   input  logic wdt_en_i,
   input  logic wdt_clr_i,
   output logic ost_done_o,
   output logic wdt_to_o
);

   localparam int CNT_MAX = (OST_TICKS > WDT_TICKS) ? OST_TICKS : WDT_TICKS;
   localparam int CNT_W   = $clog2(CNT_MAX);
   localparam logic [CNT_W-1:0] OST_LAST = CNT_W'(OST_TICKS - 1);
   localparam logic [CNT_W-1:0] WDT_LAST = CNT_W'(WDT_TICKS - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             to_q;
   logic             wdt_hit;

   assign ost_done_o = busy_i && need_ost_i && tick_ost_i && (cnt_q == OST_LAST);
   assign wdt_hit    = !busy_i && wdt_en_i && tick_wdt_i && !wdt_clr_i &&
                       (cnt_q == WDT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         to_q  <= 1'b0;
      end else begin
         to_q <= wdt_hit && !restart_i;
         if (restart_i) begin
            cnt_q <= '0;
         end else if (busy_i) begin
            if (need_ost_i && tick_ost_i) cnt_q <= cnt_q + 1'b1;
         end else if (wdt_clr_i) begin
            cnt_q <= '0;
         end else if (wdt_en_i && tick_wdt_i) begin
            cnt_q <= wdt_hit ? '0 : cnt_q + 1'b1;
         end
      end
   end

   assign wdt_to_o = to_q;

   // R6
   no_to_in_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> !to_q);

   // R7
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (cnt_q == '0));

   // R8
   to_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      to_q |=> !to_q);

endmodule

// File: rtl/clksw_ctlreg.sv
module clksw_ctlreg
   import clksw_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en_i,
   input  logic [2:0] wr_freq_i,
   input  logic [1:0] wr_sel_i,
   input  logic       int_stable_i,
   input  src_e       act_src_i,
   input  logic       busy_i,
   output logic [7:0] rd_data_o
);

   logic [2:0]             freq_q;
   logic [1:0]             sel_q;
   logic                   pri_q;
   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         freq_q <= '0;
         sel_q  <= '0;
         pri_q  <= 1'b0;
      end else begin
         pri_q <= (act_src_i == SRC_PRI) && !busy_i;
         if (wr_en_i) begin
            freq_q <= wr_freq_i;
            sel_q  <= wr_sel_i;
         end
      end
   end

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= int_stable_i;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], int_stable_i};
         end
      end
   endgenerate

   assign rd_data_o = {1'b0, freq_q, pri_q, sync_q[SYNC_STAGES-1], sel_q};

   // R10
   pri_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pri_q |-> (act_src_i == SRC_PRI));

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
   import clksw_pkg::*;
#(
   parameter int OST_TICKS   = 1024,
   parameter int WDT_TICKS   = 2048,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_freq,
   input  logic [1:0] wr_sel,
   input  logic [2:0] cfg_mode,
   input  logic       wdt_en,
   input  logic       wdt_clr,
   input  logic       tick_pri,
   input  logic       tick_int,
   input  logic       int_stable,
   output logic [7:0] rd_data,
   output logic [1:0] src_sel,
   output logic       sw_done,
   output logic       wdt_timeout
);

   generate
      if (OST_TICKS < 2 || WDT_TICKS < 2) begin : g_bad_ticks
         $error("clksw_ctrl: tick limits must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("clksw_ctrl: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic busy, start, finish, need_ost, ost_done;
   src_e act_src;

   clksw_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en),
      .wr_sel_i   (wr_sel),
      .cfg_mode_i (cfg_mode),
      .ost_done_i (ost_done),
      .busy_o     (busy),
      .start_o    (start),
      .finish_o   (finish),
      .need_ost_o (need_ost),
      .done_o     (sw_done),
      .act_src_o  (act_src)
   );

   clksw_shared_cnt #(
      .OST_TICKS (OST_TICKS),
      .WDT_TICKS (WDT_TICKS)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_i     (busy),
      .restart_i  (start || finish),
      .need_ost_i (need_ost),
      .tick_ost_i (tick_pri),
      .tick_wdt_i (tick_int),
      .wdt_en_i   (wdt_en),
      .wdt_clr_i  (wdt_clr),
      .ost_done_o (ost_done),
      .wdt_to_o   (wdt_timeout)
   );

   clksw_ctlreg #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en_i      (wr_en),
      .wr_freq_i    (wr_freq),
      .wr_sel_i     (wr_sel),
      .int_stable_i (int_stable),
      .act_src_i    (act_src),
      .busy_i       (busy),
      .rd_data_o    (rd_data)
   );

   assign src_sel = act_src;

   // R2
   done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_done |-> !busy);

endmodule

// File: tb/test_clksw_ctrl.sv
module test_clksw_ctrl;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en;
   logic [2:0] wr_freq;
   logic [1:0] wr_sel;
   logic [2:0] cfg_mode;
   logic       wdt_en, wdt_clr, tick_pri, tick_int, int_stable;
   logic [7:0] rd_data;
   logic [1:0] src_sel;
   logic       sw_done, wdt_timeout;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   always #4 clk = ~clk;

   clksw_ctrl i_clksw_ctrl (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_freq (wr_freq),
      .wr_sel (wr_sel), .cfg_mode (cfg_mode), .wdt_en (wdt_en),
      .wdt_clr (wdt_clr), .tick_pri (tick_pri), .tick_int (tick_int),
      .int_stable (int_stable), .rd_data (rd_data), .src_sel (src_sel),
      .sw_done (sw_done), .wdt_timeout (wdt_timeout)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic nclk();
      @(negedge clk);
   endtask

   task automatic reg_write(input logic [2:0] f, input logic [1:0] s);
      wr_en = 1'b1; wr_freq = f; wr_sel = s;
      nclk();
      wr_en = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; wr_en = 0; wr_freq = 0; wr_sel = 0; cfg_mode = 3'b100;
      wdt_en = 0; wdt_clr = 0; tick_pri = 0; tick_int = 0; int_stable = 1;
      repeat (3) nclk();
      chk("R1 rd_data", rd_data, 8'h00);
      chk("R1 src_sel", src_sel, 2'b10);
      chk("R1 sw_done", sw_done, 0);
      chk("R1 wdt_timeout", wdt_timeout, 0);
      rst_n = 1'b1;
      nclk();
      chk("R1 boot done", sw_done, 1);
      chk("R1 boot src", src_sel, 2'b00);
      nclk();
      chk("R2 done pulse width", sw_done, 0);
      chk("R9 R10 R11 status read", rd_data, 8'h0C);
   endtask

   task automatic t_freq();
      for (int f = 0; f < 8; f++) begin
         reg_write(3'(f), 2'b00);
         chk("R9 freq readback", rd_data, {1'b0, 3'(f), 4'b1100});
         chk("R12 same source no switch", sw_done, 0);
         nclk();
         chk("R12 same source no switch", sw_done, 0);
      end
   endtask

   task automatic t_to_int();
      reg_write(3'd0, 2'b10);
      chk("R2 src before done", src_sel, 2'b00);
      chk("R2 no early done", sw_done, 0);
      nclk();
      chk("R2 done", sw_done, 1);
      chk("R2 src int", src_sel, 2'b10);
      nclk();
      chk("R2 done pulse width", sw_done, 0);
      chk("R10 status off", rd_data, 8'h06);
   endtask

   task automatic t_reserved();
      reg_write(3'd0, 2'b11);
      for (int i = 0; i < 4; i++) begin
         chk("R4 no switch", sw_done, 0);
         chk("R4 src kept", src_sel, 2'b10);
         nclk();
      end
      chk("R4 readback 11", rd_data, 8'h07);
   endtask

   task automatic t_stable();
      int_stable = 1'b0;
      nclk();
      chk("R11 stable lag", rd_data[2], 1);
      nclk();
      chk("R11 stable low", rd_data[2], 0);
      int_stable = 1'b1;
      nclk(); nclk();
      chk("R11 stable high", rd_data[2], 1);
   endtask

   task automatic t_crystal();
      int bad_to = 0;
      int bad_done = 0;
      int bad_src = 0;
      cfg_mode = 3'b001;
      wdt_en = 1'b1; tick_int = 1'b1;
      reg_write(3'd0, 2'b00);
      for (int i = 0; i < 1024; i++) begin
         tick_pri = 1'b1;
         if (i == 10) begin wr_en = 1'b1; wr_sel = 2'b01; end
         if (i == 100) wdt_clr = 1'b1;
         nclk();
         tick_pri = 1'b0; wr_en = 1'b0; wdt_clr = 1'b0;
         if (sw_done !== (i == 1023)) bad_done++;
         if (wdt_timeout !== 1'b0) bad_to++;
         if (i < 1023) begin
            if (src_sel !== 2'b10) bad_src++;
            repeat (2) begin
               nclk();
               if (sw_done !== 1'b0) bad_done++;
               if (wdt_timeout !== 1'b0) bad_to++;
            end
         end
      end
      chk("R3 done on last tick only", bad_done, 0);
      chk("R3 src held during wait", bad_src, 0);
      chk("R6 no timeout in switch", bad_to, 0);
      chk("R3 src primary", src_sel, 2'b00);
      nclk();
      chk("R5 gap after first done", sw_done, 0);
      nclk();
      chk("R5 pending done", sw_done, 1);
      chk("R5 pending src", src_sel, 2'b01);
      bad_to = 0;
      for (int k = 0; k < 2047; k++) begin
         nclk();
         if (wdt_timeout !== 1'b0) bad_to++;
      end
      chk("R7 no early timeout", bad_to, 0);
      nclk();
      chk("R7 timeout from zero", wdt_timeout, 1);
   endtask

   task automatic t_wdt_clear();
      int bad_to = 0;
      for (int k = 0; k < 1000; k++) begin
         nclk();
         if (wdt_timeout !== 1'b0) bad_to++;
      end
      wdt_clr = 1'b1;
      nclk();
      wdt_clr = 1'b0;
      if (wdt_timeout !== 1'b0) bad_to++;
      for (int k = 0; k < 2047; k++) begin
         nclk();
         if (wdt_timeout !== 1'b0) bad_to++;
      end
      chk("R8 no timeout after clear", bad_to, 0);
      nclk();
      chk("R8 timeout", wdt_timeout, 1);
      nclk();
      chk("R8 timeout pulse width", wdt_timeout, 0);
      wdt_en = 1'b0;
   endtask

   initial begin
      t_reset();
      t_freq();
      t_to_int();
      t_reserved();
      t_stable();
      t_crystal();
      t_wdt_clear();
      if (!ended) begin
         ended = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule